// File: doc/BRIEF.md
# Two-Phase Cascaded Current-Loop Buck Controller

This block is the fixed-point control core for a two-phase synchronous buck converter. It reads three sampled values: the output voltage and the two inductor currents. Its inputs also include a programmable voltage setpoint and gain and limit registers. From these it produces one duty-cycle word per phase for a PWM generator further down the chain.

An outer proportional-integral (PI) loop acts on the voltage error and yields the total inductor current reference. That reference is halved, so that each phase carries an equal share. Each phase then runs its own inner current PI loop against its measured current, and the result is clamped into a programmable duty window.

Phase 1 is the leading phase. Its sample strobe recomputes the voltage loop, stores the new total reference and updates duty 1, all in the same cycle. The strobe of phase 2 only updates duty 2, using the stored reference without changing it. Every update is registered on the clock edge that ends its strobe cycle, and a one-cycle done pulse marks it.

Top module: `b2c_ctrl`

## Requirements
- R1: While reset is active, and in the first cycle after it, `duty1`, `duty2` and `iref_tot` are 0 and `done1` and `done2` are low. All three integrators are cleared, so the first update after reset behaves as if no earlier error existed.
- R2: The voltage error is `v_set - vout_smp`, saturated to the signed 16-bit range [-32768, 32767].
- R3: Each PI stage takes a signed 16-bit error e and signed gains with 8 fractional bits (256 = 1.0). It forms A' = A + e*ki from its accumulator A, computes s = e*kp + A', and produces the candidate output y = s >>> 8 (floor). If y lies inside the stage's limits, the output is y and A becomes A'.
- R4: Anti-windup: if the candidate output is above the upper limit or below the lower limit, the output equals that limit and the accumulator keeps its previous value.
- R5: The voltage PI limits are [-32768, 32767]. On a `ph1_valid` cycle its output is stored as the total current reference and appears on `iref_tot`.
- R6: Each phase reference is the total reference shifted right arithmetically by one bit, rounding toward minus infinity. The current error is this share minus the phase current, saturated to the signed 16-bit range. For phase 1 the share comes from the reference computed in the same cycle.
- R7: Each duty output is the current PI output clamped to [`duty_lo`, `duty_hi`], read as signed 16-bit values.
- R8: A `ph2_valid` cycle uses the `iref_tot` value held at the start of that cycle, including when `ph1_valid` is high in the same cycle. It leaves `iref_tot` and the voltage accumulator unchanged.
- R9: A strobe in cycle n updates its duty output at the end of cycle n, and its done output is high for exactly cycle n+1. Without a strobe, the duty output and the accumulator of that phase hold their values and the done output is low.
- R10: The phases are independent. A strobe of one phase changes neither the duty output nor the accumulator of the other phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ph1_valid | input | 1 | Phase-1 sample strobe; updates voltage loop and duty 1 |
| ph2_valid | input | 1 | Phase-2 sample strobe; updates duty 2 |
| vout_smp | input | 16 | Signed output-voltage sample |
| i1_smp | input | 16 | Signed phase-1 inductor current sample |
| i2_smp | input | 16 | Signed phase-2 inductor current sample |
| v_set | input | 16 | Signed voltage setpoint |
| kp_v | input | 16 | Voltage loop proportional gain, signed, 8 fractional bits |
| ki_v | input | 16 | Voltage loop integral gain, signed, 8 fractional bits |
| kp_i | input | 16 | Current loop proportional gain, shared by both phases |
| ki_i | input | 16 | Current loop integral gain, shared by both phases |
| duty_lo | input | 16 | Signed lower duty limit |
| duty_hi | input | 16 | Signed upper duty limit |
| iref_tot | output | 16 | Stored total current reference |
| duty1 | output | 16 | Phase-1 duty word |
| duty2 | output | 16 | Phase-2 duty word |
| done1 | output | 1 | One-cycle pulse after a phase-1 update |
| done2 | output | 1 | One-cycle pulse after a phase-2 update |

## Verification
The duty-window assertion assumes that `duty_lo` is not greater than `duty_hi` and that both stay stable from the strobe cycle to the following cycle. The bench changes the limit registers only during idle cycles, with no strobe pending, and always keeps the lower limit at or below the upper one. The accumulator bound used by the internal width assumes gains within the signed 16-bit range. The bench mixes modest gains, which keep the loops unclamped, with large gains and extreme samples that drive both the error saturation and the output clamps.

// File: rtl/b2c_pkg.sv
package b2c_pkg;
    localparam int unsigned SMP_W  = 16;
    localparam int unsigned ACC_W  = 40;
    localparam int unsigned Q_FRAC = 8;
    localparam int unsigned NPH    = 2;

    typedef logic signed [SMP_W-1:0] smp_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    typedef struct packed {
        acc_t             integ_v;
        acc_t [NPH-1:0]   integ_c;
        smp_t             iref;
        smp_t [NPH-1:0]   duty;
        logic [NPH-1:0]   done;
    } ctrl_st_t;
endpackage

// File: rtl/b2c_satsub.sv
module b2c_satsub
    import b2c_pkg::*;
(
    input  smp_t a,
    input  smp_t b,
    output smp_t y
);
    localparam logic signed [SMP_W:0] POS_LIM = (2 ** (SMP_W - 1)) - 1;
    localparam logic signed [SMP_W:0] NEG_LIM = -(2 ** (SMP_W - 1));

    logic signed [SMP_W:0] diff;

    always_comb begin
        diff = $signed({a[SMP_W-1], a}) - $signed({b[SMP_W-1], b});
        if (diff > POS_LIM) begin
            y = POS_LIM[SMP_W-1:0];
        end else if (diff < NEG_LIM) begin
            y = NEG_LIM[SMP_W-1:0];
        end else begin
            y = diff[SMP_W-1:0];
        end
    end
endmodule

// File: rtl/b2c_pi.sv
module b2c_pi
    import b2c_pkg::*;
#(
    parameter int unsigned FRAC = Q_FRAC
) (
    input  smp_t err,
    input  smp_t kp,
    input  smp_t ki,
    input  smp_t lo,
    input  smp_t hi,
    input  acc_t integ_q,
    output smp_t y,
    output acc_t integ_d,
    output logic clamped
);
    acc_t prod_p;
    acc_t prod_i;
    acc_t integ_try;
    acc_t sum;
    acc_t cand;

    always_comb begin
        prod_p    = acc_t'(err) * acc_t'(kp);
        prod_i    = acc_t'(err) * acc_t'(ki);
        integ_try = integ_q + prod_i;
        sum       = prod_p + integ_try;
        cand      = sum >>> FRAC;
        clamped   = 1'b0;
        if (cand > acc_t'(hi)) begin
            y       = hi;
            clamped = 1'b1;
        end else if (cand < acc_t'(lo)) begin
            y       = lo;
            clamped = 1'b1;
        end else begin
            y = cand[SMP_W-1:0];
        end
        integ_d = clamped ? integ_q : integ_try;
    end
endmodule

// File: rtl/b2c_ctrl.sv
module b2c_ctrl
    import b2c_pkg::*;
#(
    parameter int unsigned FRAC = Q_FRAC
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ph1_valid,
    input  logic ph2_valid,
    input  smp_t vout_smp,
    input  smp_t i1_smp,
    input  smp_t i2_smp,
    input  smp_t v_set,
    input  smp_t kp_v,
    input  smp_t ki_v,
    input  smp_t kp_i,
    input  smp_t ki_i,
    input  smp_t duty_lo,
    input  smp_t duty_hi,
    output smp_t iref_tot,
    output smp_t duty1,
    output smp_t duty2,
    output logic done1,
    output logic done2
);
    localparam smp_t V_LO = smp_t'(-(2 ** (SMP_W - 1)));
    localparam smp_t V_HI = smp_t'((2 ** (SMP_W - 1)) - 1);

    ctrl_st_t st_d, st_q;

    smp_t v_err, v_y;
    acc_t v_integ_d;
    logic v_clamp;

    logic [NPH-1:0] strobe;
    smp_t cur_ref   [NPH];
    smp_t cur_smp   [NPH];
    smp_t cur_err   [NPH];
    smp_t c_y       [NPH];
    acc_t c_integ_d [NPH];
    logic c_clamp   [NPH];

    // outer voltage loop
    b2c_satsub u_verr (
        .a (v_set),
        .b (vout_smp),
        .y (v_err)
    );

    b2c_pi #(.FRAC(FRAC)) u_vpi (
        .err     (v_err),
        .kp      (kp_v),
        .ki      (ki_v),
        .lo      (V_LO),
        .hi      (V_HI),
        .integ_q (st_q.integ_v),
        .y       (v_y),
        .integ_d (v_integ_d),
        .clamped (v_clamp)
    );

    // phase 0 takes the fresh reference, the others the stored one
    always_comb begin
        strobe = {ph2_valid, ph1_valid};
        for (int k = 0; k < NPH; k++) begin
            cur_ref[k] = (k == 0) ? (v_y >>> 1) : (st_q.iref >>> 1);
            cur_smp[k] = (k == 0) ? i1_smp : i2_smp;
        end
    end

    for (genvar g = 0; g < NPH; g++) begin : g_phase
        b2c_satsub u_cerr (
            .a (cur_ref[g]),
            .b (cur_smp[g]),
            .y (cur_err[g])
        );

        b2c_pi #(.FRAC(FRAC)) u_cpi (
            .err     (cur_err[g]),
            .kp      (kp_i),
            .ki      (ki_i),
            .lo      (duty_lo),
            .hi      (duty_hi),
            .integ_q (st_q.integ_c[g]),
            .y       (c_y[g]),
            .integ_d (c_integ_d[g]),
            .clamped (c_clamp[g])
        );

        // R4
        cur_windup_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (strobe[g] && c_clamp[g]) |=> $stable(st_q.integ_c[g]));

        // R9
        idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !strobe[g] |=> ($stable(st_q.duty[g]) && !st_q.done[g]));
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = '0;
        if (ph1_valid) begin
            st_d.integ_v = v_integ_d;
            st_d.iref    = v_y;
        end
        for (int k = 0; k < NPH; k++) begin
            if (strobe[k]) begin
                st_d.integ_c[k] = c_integ_d[k];
                st_d.duty[k]    = c_y[k];
                st_d.done[k]    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign iref_tot = st_q.iref;
    assign duty1    = st_q.duty[0];
    assign duty2    = st_q.duty[1];
    assign done1    = st_q.done[0];
    assign done2    = st_q.done[1];

    // R8
    ref_reuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph2_valid && !ph1_valid) |=> ($stable(iref_tot) && $stable(st_q.integ_v)));

    // R4
    volt_windup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph1_valid && v_clamp) |=> $stable(st_q.integ_v));

    // R7
    duty_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done1 |-> (duty1 >= $past(duty_lo) && duty1 <= $past(duty_hi)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ph1_valid |=> done1);
endmodule

// File: tb/b2c_ctrl_bench.sv
module b2c_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int FRAC = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ph1_valid = 1'b0, ph2_valid = 1'b0;
    logic signed [15:0] vout_smp = '0, i1_smp = '0, i2_smp = '0, v_set = '0;
    logic signed [15:0] kp_v = '0, ki_v = '0, kp_i = '0, ki_i = '0;
    logic signed [15:0] duty_lo = '0, duty_hi = '0;
    logic signed [15:0] iref_tot, duty1, duty2;
    logic done1, done2;

    int n_vec = 0;
    int n_bad = 0;

    // reference model state
    longint m_acc_v = 0, m_acc_1 = 0, m_acc_2 = 0;
    int m_iref = 0, m_d1 = 0, m_d2 = 0;
    bit m_dn1 = 0, m_dn2 = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    b2c_ctrl u_b2c_ctrl (
        .clk(clk), .rst_n(rst_n), .ph1_valid(ph1_valid), .ph2_valid(ph2_valid),
        .vout_smp(vout_smp), .i1_smp(i1_smp), .i2_smp(i2_smp), .v_set(v_set),
        .kp_v(kp_v), .ki_v(ki_v), .kp_i(kp_i), .ki_i(ki_i),
        .duty_lo(duty_lo), .duty_hi(duty_hi),
        .iref_tot(iref_tot), .duty1(duty1), .duty2(duty2),
        .done1(done1), .done2(done2)
    );

    function automatic int sat16(longint x);
        if (x > 32767) return 32767;
        if (x < -32768) return -32768;
        return int'(x);
    endfunction

    // R3 R4: PI law with conditional integration
    function automatic int pi_model(int e, int kp, int ki, int lo, int hi, ref longint acc);
        longint nxt, s, y;
        nxt = acc + longint'(e) * longint'(ki);
        s   = longint'(e) * longint'(kp) + nxt;
        y   = s >>> FRAC;
        if (y > hi) return hi;
        if (y < lo) return lo;
        acc = nxt;
        return int'(y);
    endfunction

    // next model state for the inputs present at the coming edge
    task automatic model_step();
        int old_ref, e, share;
        m_dn1 = 0;
        m_dn2 = 0;
        if (!rst_n) begin
            m_acc_v = 0; m_acc_1 = 0; m_acc_2 = 0;  // R1
            m_iref = 0; m_d1 = 0; m_d2 = 0;
            return;
        end
        old_ref = m_iref;
        if (ph1_valid) begin
            e      = sat16(longint'(v_set) - longint'(vout_smp));            // R2
            m_iref = pi_model(e, kp_v, ki_v, -32768, 32767, m_acc_v);       // R5
            share  = m_iref >>> 1;                                           // R6
            e      = sat16(longint'(share) - longint'(i1_smp));
            m_d1   = pi_model(e, kp_i, ki_i, duty_lo, duty_hi, m_acc_1);    // R7
            m_dn1  = 1;
        end
        if (ph2_valid) begin
            share = old_ref >>> 1;                                           // R8
            e     = sat16(longint'(share) - longint'(i2_smp));
            m_d2  = pi_model(e, kp_i, ki_i, duty_lo, duty_hi, m_acc_2);     // R10
            m_dn2 = 1;
        end
    endtask

    task automatic chk(string tag, int act, int exp);
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    // compare all outputs at the falling edge, then apply the next vector
    task automatic compare_all();
        n_vec++;
        chk("R5 R8 iref_tot", int'(iref_tot), m_iref);
        chk("R3 R6 R7 duty1", int'(duty1), m_d1);
        chk("R8 R10 duty2", int'(duty2), m_d2);
        chk("R9 done1", int'(done1), int'(m_dn1));
        chk("R9 done2", int'(done2), int'(m_dn2));
    endtask

    task automatic cycle();
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic rnd_vec(int amp, int p1_pct, int p2_pct);
        vout_smp  = 16'(($urandom % (2 * amp + 1)) - amp);
        i1_smp    = 16'(($urandom % (2 * amp + 1)) - amp);
        i2_smp    = 16'(($urandom % (2 * amp + 1)) - amp);
        ph1_valid = ($urandom % 100) < p1_pct;
        ph2_valid = ($urandom % 100) < p2_pct;
    endtask

    task automatic idle_set_limits(int lo, int hi);
        ph1_valid = 0;
        ph2_valid = 0;
        cycle();
        duty_lo = 16'(lo);
        duty_hi = 16'(hi);
        cycle();
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 3; i++) cycle();
        rst_n = 1;
        v_set = 16'sd4000; kp_v = 16'sd300; ki_v = 16'sd20;
        kp_i = 16'sd200; ki_i = 16'sd10;
        idle_set_limits(50, 3000);

        // R3 R5 R6: modest gains, mixed strobes
        for (int i = 0; i < 400; i++) begin
            rnd_vec(3000, 40, 40);
            cycle();
        end

        // R8: phase-2 only, reference must hold
        for (int i = 0; i < 30; i++) begin
            rnd_vec(3000, 0, 70);
            cycle();
        end

        // R9: both strobes in the same cycle, then idle gaps
        for (int i = 0; i < 40; i++) begin
            rnd_vec(2000, 100, 100);
            cycle();
            ph1_valid = 0; ph2_valid = 0;
            cycle();
        end

        // R2 R4 R7: extreme samples and large gains force saturation and clamps
        idle_set_limits(100, 900);
        kp_v = 16'sd20000; ki_v = 16'sd3000; kp_i = 16'sd15000; ki_i = 16'sd2000;
        for (int i = 0; i < 300; i++) begin
            v_set = (i % 2 == 0) ? 16'sd32767 : -16'sd32768;
            rnd_vec(32767, 60, 60);
            cycle();
        end

        // R4: windup recovery with small gains and a negative window
        kp_v = 16'sd256; ki_v = 16'sd16; kp_i = 16'sd128; ki_i = 16'sd8;
        v_set = 16'sd1000;
        idle_set_limits(-500, 500);
        for (int i = 0; i < 300; i++) begin
            rnd_vec(1500, 50, 50);
            cycle();
        end

        // R1: reset mid-run clears outputs and integrators
        rst_n = 0;
        ph1_valid = 0; ph2_valid = 0;
        cycle();
        cycle();
        rst_n = 1;
        cycle();
        for (int i = 0; i < 200; i++) begin
            rnd_vec(3000, 50, 50);
            cycle();
        end

        ph1_valid = 0; ph2_valid = 0;
        cycle();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog t=%0t actual=hung expected=finished", $time);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule